// File: doc/BRIEF.md
# Simultaneous Self-Test Scan Chain

This block is a small sequential circuit whose sixteen state flip-flops each double as a self-test element. A cell can take the functional next-state value from the circuit's combinational logic, move its neighbour's value along a serial path, or take the exclusive-OR of both. In the third case the chain feeds stimuli into the logic and folds the logic's responses back into itself on the same clock edge. No pattern generator or response compactor sits beside it. Both clocks of a classic two-clock cell are modelled as enables on a single clock.

A small sequencer runs the test. A start pulse latches a test length and an expected signature. The sequencer then shifts a 16-bit seed in from `scan_in`, runs the requested number of self-test clocks, and shifts the chain out through `scan_out`. While the chain shifts out, the sequencer gathers the bits into a signature and compares it with the expected one. It raises `done` and reports the outcome on `pass` until the next start. When no test is running, `func_en` clocks the circuit in its normal mode.

Top module: `sst_chain_top`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, the sequencer is idle, `chain_q` is all zeros, and `busy`, `done` and `pass` are 0.
- R2: When the sequencer is idle or done and `func_en` is 1, every clock loads the chain with the circuit's next state. Bit i of that state is q[(i+1)%16] ^ (q[(i+3)%16] & ~q[(i+5)%16]) ^ cut_in[i%4]. With `func_en` at 0 in those states, the chain holds its value.
- R3: A start pulse accepted in the idle or done state makes `busy` 1 after that edge. There follow exactly 16 shift clocks. On each one, cell 0 takes `scan_in` and cell i takes cell i-1. The first bit shifted in therefore ends in cell 15, and after the 16th clock `chain_q` equals the seed.
- R4: In the self-test state, each clock sets cell i to D[i] ^ q[i-1], and sets cell 0 to D[0] ^ q[15]. `scan_in` and `func_en` have no effect. The state lasts exactly the test length latched at start.
- R5: A latched test length of 0 sends the sequencer from seed loading straight to shifting out, with no self-test clock.
- R6: Shifting out takes exactly 16 shift clocks, with the same shift rule as R3. `scan_out` always shows cell 15. The signature is the sequence of `scan_out` values, first bit in its bit 15, so it equals the chain contents at the end of self-test.
- R7: After the last shift-out clock, `done` is 1 and `busy` is 0. `pass` is 1 exactly when the signature equals the expected value latched at start. Both hold until a new start is accepted, which clears `pass`.
- R8: A start pulse is ignored while `busy` is 1. It changes neither the latched length and expected value nor the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; mode enables gate it |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | 1 | Functional capture enable when no test runs |
| cut_in | input | 4 | Primary inputs of the combinational logic |
| start | input | 1 | Pulse that begins a test sequence |
| test_len | input | 16 | Number of self-test clocks, latched at start |
| golden | input | 16 | Expected signature, latched at start |
| scan_in | input | 1 | Serial data into cell 0 during shifting |
| scan_out | output | 1 | Serial data from cell 15 |
| chain_q | output | 16 | State of the chain cells, also the circuit's outputs |
| busy | output | 1 | A test sequence is loading, running or unloading |
| done | output | 1 | The sequence has finished and `pass` is valid |
| pass | output | 1 | Signature matched the expected value |

## Verification
The assertions assume that `cut_in` holds its value across a clock edge and that reset is synchronous. The stimulus changes inputs only at falling edges, so every edge sees stable values. The assertions also assume that only the sequencer chooses a mode, so a start pulse or `func_en` can arrive at any time, including in the middle of a test. The stimulus relies on this: it raises `func_en`, toggles `scan_in` and pulses `start` while self-test is running, and a behavioural model that honours start only when idle or done follows it. Test lengths of 0, 1 and several dozen, matching and mismatching expected values, and several seeds and input patterns cover the boundaries of the sequence.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int CHAIN_N = 16;
  localparam int PI_W    = 4;
  localparam int LEN_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_TEST,
    ST_UNLOAD,
    ST_DONE
  } sst_state_e;
endpackage

// File: rtl/sst_cell.sv
// One self-test storage element: functional capture, serial shift,
// or capture of functional data XOR serial input.
module sst_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ck1_en,
  input  logic ck2_en,
  input  logic t_sel,
  input  logic d,
  input  logic si,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= 1'b0;
    else if (ck2_en) q <= t_sel ? (d ^ si) : si;
    else if (ck1_en) q <= d;
  end
endmodule

// File: rtl/sst_cut.sv
// Combinational logic of the circuit under test: next state from state and inputs.
module sst_cut #(
  parameter int N   = sst_pkg::CHAIN_N,
  parameter int PIW = sst_pkg::PI_W
) (
  input  logic [N-1:0]   q,
  input  logic [PIW-1:0] pi,
  output logic [N-1:0]   d
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    assign d[gi] = q[(gi+1)%N] ^ (q[(gi+3)%N] & ~q[(gi+5)%N]) ^ pi[gi%PIW];
  end
endmodule

// File: rtl/sst_ctrl.sv
// Sequencer: seed load, self-test run, unload with signature compare.
module sst_ctrl #(
  parameter int N     = sst_pkg::CHAIN_N,
  parameter int LEN_W = sst_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             start,
  input  logic [LEN_W-1:0] test_len,
  input  logic [N-1:0]     golden,
  input  logic             scan_out,
  output logic             ck1_en,
  output logic             ck2_en,
  output logic             t_sel,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  import sst_pkg::*;

  localparam logic [LEN_W-1:0] LAST_SHIFT = LEN_W'(N - 1);

  sst_state_e       st_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [N-1:0]     gold_q;
  logic [N-1:0]     sig_q;
  logic             pass_q;

  logic idle_like, shifting, testing, accept, last_shift, last_test;
  logic [N-1:0] sig_next;

  assign idle_like  = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign shifting   = (st_q == ST_LOAD) || (st_q == ST_UNLOAD);
  assign testing    = (st_q == ST_TEST);
  assign accept     = idle_like && start;
  assign last_shift = (cnt_q == LAST_SHIFT);
  assign last_test  = (cnt_q == LEN_W'(len_q - 1'b1));
  assign sig_next   = {sig_q[N-2:0], scan_out};

  assign ck1_en = idle_like && func_en;
  assign ck2_en = shifting || testing;
  assign t_sel  = testing;
  assign busy   = !idle_like;
  assign done   = (st_q == ST_DONE);
  assign pass   = pass_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      gold_q <= '0;
      sig_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            st_q   <= ST_LOAD;
            cnt_q  <= '0;
            len_q  <= test_len;
            gold_q <= golden;
            pass_q <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (last_shift) begin
            st_q  <= (len_q == '0) ? ST_UNLOAD : ST_TEST;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TEST: begin
          if (last_test) begin
            st_q  <= ST_UNLOAD;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_UNLOAD: begin
          sig_q <= sig_next;
          if (last_shift) begin
            st_q   <= ST_DONE;
            cnt_q  <= '0;
            pass_q <= (sig_next == gold_q);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sst_chain_top.sv
module sst_chain_top #(
  parameter int N     = sst_pkg::CHAIN_N,
  parameter int PIW   = sst_pkg::PI_W,
  parameter int LEN_W = sst_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic [PIW-1:0]   cut_in,
  input  logic             start,
  input  logic [LEN_W-1:0] test_len,
  input  logic [N-1:0]     golden,
  input  logic             scan_in,
  output logic             scan_out,
  output logic [N-1:0]     chain_q,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  // Named internal events for the checker
  logic         norm_en, ck2_en, t_sel, shift_en, test_en;
  logic [N-1:0] d_vec;
  logic [N-1:0] si_vec;

  sst_ctrl #(.N(N), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .start(start),
    .test_len(test_len), .golden(golden), .scan_out(scan_out),
    .ck1_en(norm_en), .ck2_en(ck2_en), .t_sel(t_sel),
    .busy(busy), .done(done), .pass(pass)
  );

  sst_cut #(.N(N), .PIW(PIW)) u_cut (
    .q(chain_q), .pi(cut_in), .d(d_vec)
  );

  assign shift_en = ck2_en && !t_sel;
  assign test_en  = ck2_en && t_sel;

  // Cell 0 takes the external serial input when shifting, the ring tail in self-test
  assign si_vec[0] = t_sel ? chain_q[N-1] : scan_in;

  for (genvar gi = 0; gi < N; gi++) begin : g_cell
    if (gi > 0) begin : g_link
      assign si_vec[gi] = chain_q[gi-1];
    end
    sst_cell u_cell (
      .clk(clk), .rst_n(rst_n), .ck1_en(norm_en), .ck2_en(ck2_en),
      .t_sel(t_sel), .d(d_vec[gi]), .si(si_vec[gi]), .q(chain_q[gi])
    );
  end

  assign scan_out = chain_q[N-1];
endmodule

// File: rtl/sst_chain_chk.sv
module sst_chain_chk #(
  parameter int N = sst_pkg::CHAIN_N
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         pass,
  input logic [N-1:0] chain_q,
  input logic [N-1:0] d_vec,
  input logic         shift_en,
  input logic         test_en,
  input logic         norm_en
);
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_en, test_en, norm_en})); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (chain_q[N-1:1] == $past(chain_q[N-2:0]))); // R3

  AST_TEST_RING: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |=> (chain_q[0] == ($past(d_vec[0]) ^ $past(chain_q[N-1])))); // R4

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !test_en && !norm_en) |=> $stable(chain_q)); // R2

  AST_PASS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done); // R7

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass))); // R7
endmodule

bind sst_chain_top sst_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .chain_q(chain_q), .d_vec(d_vec), .shift_en(shift_en),
  .test_en(test_en), .norm_en(norm_en)
);

// File: tb/sst_chain_top_tb.sv
module sst_chain_top_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        func_en, start, scan_in;
  logic [3:0]  cut_in;
  logic [15:0] test_len, golden;
  logic        scan_out, busy, done, pass;
  logic [15:0] chain_q;

  always #5 clk = ~clk;

  sst_chain_top u_dut (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .cut_in(cut_in),
    .start(start), .test_len(test_len), .golden(golden), .scan_in(scan_in),
    .scan_out(scan_out), .chain_q(chain_q), .busy(busy), .done(done), .pass(pass)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // Behavioural model: 0 idle, 1 load, 2 test, 3 unload, 4 done
  int          m_st;
  int          m_cnt;
  int          m_len;
  logic [15:0] m_gold, m_sig, m_q;
  logic        m_pass;

  function automatic logic [15:0] next_state(logic [15:0] q, logic [3:0] pi);
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = q[(i+1)%16] ^ (q[(i+3)%16] & ~q[(i+5)%16]) ^ pi[i%4];
    return r;
  endfunction

  function automatic logic [15:0] expect_sig(logic [15:0] seed, int len, logic [3:0] pi);
    logic [15:0] q = seed;
    for (int k = 0; k < len; k++) q = next_state(q, pi) ^ {q[14:0], q[15]};
    return q;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic string req_of(int st);
    case (st)
      1: return "R3";
      2: return "R4";
      3: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic model_update();
    logic [15:0] q0 = m_q;
    case (m_st)
      0, 4: begin
        if (func_en) m_q = next_state(q0, cut_in);
        if (start) begin
          m_st = 1; m_cnt = 0; m_len = int'(test_len); m_gold = golden; m_pass = 1'b0;
        end
      end
      1: begin
        m_q = {q0[14:0], scan_in};
        if (m_cnt == 15) begin m_st = (m_len == 0) ? 3 : 2; m_cnt = 0; end
        else m_cnt++;
      end
      2: begin
        m_q = next_state(q0, cut_in) ^ {q0[14:0], q0[15]};
        if (m_cnt == m_len - 1) begin m_st = 3; m_cnt = 0; end
        else m_cnt++;
      end
      3: begin
        m_sig = {m_sig[14:0], q0[15]};
        m_q = {q0[14:0], scan_in};
        if (m_cnt == 15) begin m_st = 4; m_cnt = 0; m_pass = (m_sig == m_gold); end
        else m_cnt++;
      end
      default: m_st = 0;
    endcase
  endtask

  task automatic step();
    int prev = m_st;
    @(posedge clk);
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_q = '0; m_pass = 1'b0; m_sig = '0;
    end else model_update();
    @(negedge clk);
    check(req_of(prev), 32'(chain_q), 32'(m_q), "chain_q");
    check("R6", 32'(scan_out), 32'(m_q[15]), "scan_out");
    check(req_of(prev), 32'(busy), 32'(m_st inside {1, 2, 3}), "busy");
    check("R7", 32'(done), 32'(m_st == 4), "done");
    check("R7", 32'(pass), 32'(m_pass), "pass");
  endtask

  // Runs one sequence; optionally pulses start with other values during self-test
  task automatic run_seq(logic [15:0] seed, int len, logic [15:0] gold,
                         logic [3:0] pi, bit disturb);
    cut_in = pi; test_len = 16'(len); golden = gold; start = 1'b1;
    step();
    start = 1'b0;
    check("R3", 32'(busy), 32'd1, "busy after start");
    for (int k = 0; k < 16; k++) begin
      scan_in = seed[15-k];
      step();
    end
    check("R3", 32'(chain_q), 32'(seed), "seed after load");
    for (int k = 0; k < len; k++) begin
      scan_in = k[0];
      func_en = k[1];
      if (disturb && k == 2) begin
        start = 1'b1; test_len = 16'd3; golden = ~gold;
      end
      step();
      start = 1'b0;
    end
    func_en = 1'b0;
    check(len == 0 ? "R5" : "R4", 32'(chain_q), 32'(expect_sig(seed, len, pi)),
          "chain after self-test");
    for (int k = 0; k < 16; k++) begin
      scan_in = k[2];
      step();
    end
    check("R6", 32'(done), 32'd1, "done after 16 unload clocks");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual no completion expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    rst_n = 1'b0; func_en = 1'b0; start = 1'b0; scan_in = 1'b0;
    cut_in = 4'h0; test_len = '0; golden = '0;
    m_st = 0; m_cnt = 0; m_len = 0; m_gold = '0; m_sig = '0; m_q = '0; m_pass = 1'b0;
    @(negedge clk);
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1", 32'({busy, done, pass}), 32'd0, "status after reset");
    check("R1", 32'(chain_q), 32'd0, "chain after reset");

    // R2: functional mode with varying inputs, then hold
    func_en = 1'b1;
    for (int k = 0; k < 6; k++) begin cut_in = 4'(k * 5 + 3); step(); end
    func_en = 1'b0;
    g = chain_q;
    step(); step();
    check("R2", 32'(chain_q), 32'(g), "hold with func_en low");

    // R7 matching signature
    g = expect_sig(16'hA5C3, 37, 4'h9);
    run_seq(16'hA5C3, 37, g, 4'h9, 1'b0);
    check("R7", 32'(pass), 32'd1, "pass with matching golden");
    step(); step();
    check("R7", 32'(pass), 32'd1, "pass held in done");

    // R7 mismatch
    g = expect_sig(16'h3C01, 20, 4'h6);
    run_seq(16'h3C01, 20, g ^ 16'h0100, 4'h6, 1'b0);
    check("R7", 32'(pass), 32'd0, "pass with wrong golden");

    // R5 zero length, R1-style length one boundary
    run_seq(16'hF00F, 0, 16'hF00F, 4'h1, 1'b0);
    check("R5", 32'(pass), 32'd1, "zero length returns the seed");
    g = expect_sig(16'h8001, 1, 4'hA);
    run_seq(16'h8001, 1, g, 4'hA, 1'b0);
    check("R4", 32'(pass), 32'd1, "length one");

    // R8 start while busy ignored
    g = expect_sig(16'h5A5A, 12, 4'hC);
    run_seq(16'h5A5A, 12, g, 4'hC, 1'b1);
    check("R8", 32'(pass), 32'd1, "start during test ignored");

    // R2 functional capture from the done state
    func_en = 1'b1; cut_in = 4'h7;
    for (int k = 0; k < 3; k++) step();
    func_en = 1'b0;
    check("R7", 32'(done), 32'd1, "done held under functional clocks");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule